// File: doc/BRIEF.md
# Watchdog and Reset Pulse Generator

This block drives the processor reset lines and a latched watchdog fault flag. It takes a supply-low flag from an analog comparator, a watchdog kick level from software, a flag that reports the kick input as left open, a battery-backup flag and a two-bit timeout-mode select. Every period is counted in ticks of a timebase enable, so the same logic serves a slow internal oscillator or an external clock.

While the supply is low the reset lines are asserted; after the supply recovers they stay asserted for one reset timeout. Once reset releases, the kick input must change level within a watchdog period. The first period after any reset is longer than the normal one. A missed period pulls the fault flag low and starts a new reset pulse; the flag stays low until the kick input moves again. A kick input stuck at one level therefore gives a train of reset pulses.

The control is a five-state machine. `ST_HOLD` (supply low) goes to `ST_RST_TMO` once the supply flag clears. `ST_RST_TMO` (reset timeout running) goes to `ST_WD_LONG` after the reset timeout. `ST_WD_LONG` (first watch period after reset) and `ST_WD_NORM` (normal watch period) go to `ST_WD_NORM` on a kick, to `ST_WD_OFF` when the watchdog is disabled, and to `ST_RST_TMO` on expiry. `ST_WD_OFF` (watchdog disabled, reset released) goes to `ST_WD_NORM` when it is enabled again. Any state goes to `ST_HOLD` while the supply flag is set.

Top module: `wdg_reset_pulse_gen`

## Requirements
- R1: While low_line is 1, rst_n is 0 from the next clock on and wdo_n is 1, and any latched fault is cleared.
- R2: After low_line falls, rst_n stays 0 for exactly the reset timeout in ticks (one tick per clock: that many clocks after the clock that samples low_line low), then rises.
- R3: rst is always the logical inverse of rst_n.
- R4: Each level change of wdi, rising or falling, restarts the watchdog count; a pulse one clock wide counts as two changes. A change acts on the third rising clock edge after it, because of a two-flop synchroniser and a compare stage.
- R5: The first watch period after reset releases is the after-reset period; the period after a kick is the normal period.
- R6: When a watch period expires with no kick, wdo_n goes low and rst_n goes low on the same clock, and reset lasts one reset timeout.
- R7: wdo_n stays low after the reset pulse ends and returns high only on a wdi change (or a disable condition of R1 or R9).
- R8: With wdi held at one level, rst_n repeats: low for one reset timeout, high for one after-reset period.
- R9: While wdi_float or batt_mode is 1, no watchdog expiry occurs and wdo_n is 1; an ongoing reset pulse completes. When both clear, a normal period starts on the next clock.
- R10: tmo_mode 2'b00 selects the external-clock counts (defaults: reset 2048, normal 1024, after-reset 4096 ticks); 2'b01 selects the fast internal set (200, 100, 1600 ticks at a 1 kHz tick); 2'b10 and 2'b11 select the default internal set (200, 1600, 1600 ticks).
- R11: Counting advances only on clocks with tick = 1; with tick held 0, reset never releases and no watch period expires.
- R12: While rst_ni is 0 the block is in ST_HOLD: rst_n = 0, rst = 1, wdo_n = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Timebase enable, one per period unit |
| low_line | input | 1 | Supply below threshold |
| wdi | input | 1 | Watchdog kick level (asynchronous) |
| wdi_float | input | 1 | Kick input left open; disables the watchdog |
| batt_mode | input | 1 | Battery-backup active; disables the watchdog |
| tmo_mode | input | 2 | Timeout set select (see R10) |
| rst_n | output | 1 | Processor reset, active low |
| rst | output | 1 | Processor reset, active high |
| wdo_n | output | 1 | Latched watchdog fault, active low |

## Verification
Supply effects show up one clock after the clock that samples low_line, and the reset timeout adds exactly its tick count after that. A wdi change shows up on wdo_n two clocks later than a supply change, on the third edge, and a watch period ends its tick count after the clock that started it. The bench drives inputs on the falling edge and counts falling-edge samples of rst_n and wdo_n. It compares those counts with figures derived from these latencies, so that a period off by one clock is reported. With a divided tick, where the phase is free, it checks a window of one tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_RST_TMO = 3'd1,
        ST_WD_LONG = 3'd2,
        ST_WD_NORM = 3'd3,
        ST_WD_OFF  = 3'd4
    } wdg_state_e;

    typedef enum logic [1:0] {
        MODE_EXT      = 2'b00,
        MODE_FAST     = 2'b01,
        MODE_SLOW     = 2'b10,
        MODE_SLOW_ALT = 2'b11
    } wdg_mode_e;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdg_kick_detect.sv
module wdg_kick_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_ni,
    input  logic wdi,
    output logic kick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_ni) begin
                    if (!rst_ni) sync_q[0] <= 1'b0;
                    else         sync_q[0] <= wdi;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_ni) begin
                    if (!rst_ni) sync_q[i] <= 1'b0;
                    else         sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign kick = sync_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/wdg_period_sel.sv
module wdg_period_sel
    import wdg_pkg::*;
#(
    parameter int CW                = 13,
    parameter int EXT_RST_TICKS     = 2048,
    parameter int EXT_WD_TICKS      = 1024,
    parameter int EXT_WD_1ST_TICKS  = 4096,
    parameter int FAST_RST_TICKS    = 200,
    parameter int FAST_WD_TICKS     = 100,
    parameter int FAST_WD_1ST_TICKS = 1600,
    parameter int SLOW_RST_TICKS    = 200,
    parameter int SLOW_WD_TICKS     = 1600
) (
    input  logic [1:0]    mode,
    output logic [CW-1:0] rst_len,
    output logic [CW-1:0] wd_len,
    output logic [CW-1:0] wd_1st_len
);
    always_comb begin
        unique case (wdg_mode_e'(mode))
            MODE_EXT: begin
                rst_len    = CW'(EXT_RST_TICKS);
                wd_len     = CW'(EXT_WD_TICKS);
                wd_1st_len = CW'(EXT_WD_1ST_TICKS);
            end
            MODE_FAST: begin
                rst_len    = CW'(FAST_RST_TICKS);
                wd_len     = CW'(FAST_WD_TICKS);
                wd_1st_len = CW'(FAST_WD_1ST_TICKS);
            end
            MODE_SLOW, MODE_SLOW_ALT: begin
                rst_len    = CW'(SLOW_RST_TICKS);
                wd_len     = CW'(SLOW_WD_TICKS);
                wd_1st_len = CW'(SLOW_WD_TICKS);
            end
            default: begin
                rst_len    = CW'(SLOW_RST_TICKS);
                wd_len     = CW'(SLOW_WD_TICKS);
                wd_1st_len = CW'(SLOW_WD_TICKS);
            end
        endcase
    end

endmodule

// File: rtl/wdg_tick_count.sv
module wdg_tick_count #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_ni,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_TOP = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)                      cnt_q <= '0;
        else if (clr)                     cnt_q <= '0;
        else if (inc && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wdg_reset_pulse_gen.sv
module wdg_reset_pulse_gen
    import wdg_pkg::*;
#(
    parameter int SYNC_STAGES       = 2,
    parameter int EXT_RST_TICKS     = 2048,
    parameter int EXT_WD_TICKS      = 1024,
    parameter int EXT_WD_1ST_TICKS  = 4096,
    parameter int FAST_RST_TICKS    = 200,
    parameter int FAST_WD_TICKS     = 100,
    parameter int FAST_WD_1ST_TICKS = 1600,
    parameter int SLOW_RST_TICKS    = 200,
    parameter int SLOW_WD_TICKS     = 1600
) (
    input  logic       clk,
    input  logic       rst_ni,
    input  logic       tick,
    input  logic       low_line,
    input  logic       wdi,
    input  logic       wdi_float,
    input  logic       batt_mode,
    input  logic [1:0] tmo_mode,
    output logic       rst_n,
    output logic       rst,
    output logic       wdo_n
);
    localparam int MAXP = max_of3(
        max_of3(EXT_RST_TICKS, EXT_WD_TICKS, EXT_WD_1ST_TICKS),
        max_of3(FAST_RST_TICKS, FAST_WD_TICKS, FAST_WD_1ST_TICKS),
        max_of3(SLOW_RST_TICKS, SLOW_WD_TICKS, 1));
    localparam int CW = $clog2(MAXP + 1);

    wdg_state_e    state_q, state_d;
    logic          kick;
    logic          wd_off;
    logic          cnt_clr;
    logic          fault_set;
    logic          fault_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rst_len, wd_len, wd_1st_len, watch_len;

    wdg_kick_detect #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
        .clk    (clk),
        .rst_ni (rst_ni),
        .wdi    (wdi),
        .kick   (kick)
    );

    wdg_period_sel #(
        .CW                (CW),
        .EXT_RST_TICKS     (EXT_RST_TICKS),
        .EXT_WD_TICKS      (EXT_WD_TICKS),
        .EXT_WD_1ST_TICKS  (EXT_WD_1ST_TICKS),
        .FAST_RST_TICKS    (FAST_RST_TICKS),
        .FAST_WD_TICKS     (FAST_WD_TICKS),
        .FAST_WD_1ST_TICKS (FAST_WD_1ST_TICKS),
        .SLOW_RST_TICKS    (SLOW_RST_TICKS),
        .SLOW_WD_TICKS     (SLOW_WD_TICKS)
    ) u_sel (
        .mode       (tmo_mode),
        .rst_len    (rst_len),
        .wd_len     (wd_len),
        .wd_1st_len (wd_1st_len)
    );

    wdg_tick_count #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_ni (rst_ni),
        .clr    (cnt_clr),
        .inc    (tick && !cnt_clr),
        .cnt    (cnt_q)
    );

    assign wd_off    = wdi_float || batt_mode;
    assign watch_len = (state_q == ST_WD_LONG) ? wd_1st_len : wd_len;

    // State register
    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HOLD;
        else         state_q <= state_d;
    end

    // Next state, counter clear and expiry
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        fault_set = 1'b0;
        if (low_line) begin
            state_d = ST_HOLD;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    state_d = ST_RST_TMO;
                    cnt_clr = 1'b1;
                end
                ST_RST_TMO: begin
                    if (tick && cnt_q >= rst_len - 1'b1) begin
                        state_d = ST_WD_LONG;
                        cnt_clr = 1'b1;
                    end
                end
                ST_WD_LONG, ST_WD_NORM: begin
                    if (wd_off) begin
                        state_d = ST_WD_OFF;
                        cnt_clr = 1'b1;
                    end else if (kick) begin
                        state_d = ST_WD_NORM;
                        cnt_clr = 1'b1;
                    end else if (tick && cnt_q >= watch_len - 1'b1) begin
                        state_d   = ST_RST_TMO;
                        cnt_clr   = 1'b1;
                        fault_set = 1'b1;
                    end
                end
                ST_WD_OFF: begin
                    cnt_clr = 1'b1;
                    if (!wd_off) state_d = ST_WD_NORM;
                end
                default: begin
                    state_d = ST_HOLD;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // Latched fault: set on expiry, cleared by a kick or a disable condition
    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)                 fault_q <= 1'b0;
        else if (low_line || wd_off) fault_q <= 1'b0;
        else if (kick)               fault_q <= 1'b0;
        else if (fault_set)          fault_q <= 1'b1;
    end

    // Outputs
    always_comb begin
        rst_n = 1'b0;
        rst   = 1'b1;
        unique case (state_q)
            ST_HOLD, ST_RST_TMO:             rst   = 1'b1;
            ST_WD_LONG, ST_WD_NORM, ST_WD_OFF: rst_n = 1'b1;
            default:                         rst   = 1'b1;
        endcase
        if (state_q inside {ST_WD_LONG, ST_WD_NORM, ST_WD_OFF}) rst = 1'b0;
        wdo_n = !fault_q;
    end

endmodule

// File: rtl/wdg_reset_pulse_gen_chk.sv
module wdg_reset_pulse_gen_chk #(
    parameter int CW   = 13,
    parameter int MAXP = 4096
) (
    input logic          clk,
    input logic          rst_ni,
    input logic          low_line,
    input logic          wdi_float,
    input logic          batt_mode,
    input logic          kick,
    input logic [CW-1:0] cnt,
    input logic          rst_n,
    input logic          rst,
    input logic          wdo_n
);
    assert_rst_pair_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        rst == !rst_n);

    assert_lowline_R1: assert property (@(posedge clk) disable iff (!rst_ni)
        low_line |=> (!rst_n && wdo_n));

    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        (wdi_float || batt_mode) |=> wdo_n);

    assert_fault_rst_R6: assert property (@(posedge clk) disable iff (!rst_ni)
        $fell(wdo_n) |-> !rst_n);

    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(rst_n) |-> !$past(low_line));

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(wdo_n) |-> $past(kick || low_line || wdi_float || batt_mode));

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_ni)
        cnt < CW'(MAXP));

endmodule

bind wdg_reset_pulse_gen wdg_reset_pulse_gen_chk #(.CW(CW), .MAXP(MAXP)) chk_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .low_line  (low_line),
    .wdi_float (wdi_float),
    .batt_mode (batt_mode),
    .kick      (kick),
    .cnt       (cnt_q),
    .rst_n     (rst_n),
    .rst       (rst),
    .wdo_n     (wdo_n)
);

// File: tb/wdg_reset_pulse_gen_tb_top.sv
module wdg_reset_pulse_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int E_RST = 8,  E_WD = 5,  E_WDF = 20;
    localparam int F_RST = 6,  F_WD = 3,  F_WDF = 12;
    localparam int S_RST = 7,  S_WD = 15;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tick = 1'b0;
    logic       low_line = 1'b1;
    logic       wdi = 1'b0;
    logic       wdi_float = 1'b0;
    logic       batt_mode = 1'b0;
    logic [1:0] tmo_mode = 2'b00;
    logic       rst_n, rst, wdo_n;

    int total = 0;
    int bad = 0;
    int tick_every = 1;
    int ph = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (tick_every == 0) begin
            tick = 1'b0;
            ph = 0;
        end else begin
            tick = (ph == 0);
            ph = (ph + 1) % tick_every;
        end
    end

    wdg_reset_pulse_gen #(
        .EXT_RST_TICKS(E_RST), .EXT_WD_TICKS(E_WD), .EXT_WD_1ST_TICKS(E_WDF),
        .FAST_RST_TICKS(F_RST), .FAST_WD_TICKS(F_WD), .FAST_WD_1ST_TICKS(F_WDF),
        .SLOW_RST_TICKS(S_RST), .SLOW_WD_TICKS(S_WD)
    ) dut_i (
        .clk(clk), .rst_ni(rst_ni), .tick(tick), .low_line(low_line),
        .wdi(wdi), .wdi_float(wdi_float), .batt_mode(batt_mode),
        .tmo_mode(tmo_mode), .rst_n(rst_n), .rst(rst), .wdo_n(wdo_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts consecutive falling-edge samples, from the current one, with rst_n == lvl
    task automatic count_run(input logic lvl, output int n);
        n = 0;
        while (rst_n === lvl && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic restart_supply();
        low_line = 1'b1;
        repeat (3) @(negedge clk);
        low_line = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R12 rst_n in block reset", int'(rst_n), 0);
        chk("R3 rst in block reset", int'(rst), 1);
        chk("R12 wdo_n in block reset", int'(wdo_n), 1);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rst_n while low_line", int'(rst_n), 0);
        chk("R1 wdo_n while low_line", int'(wdo_n), 1);
    endtask

    task automatic t_power_up_and_stuck();
        int n;
        low_line = 1'b0;
        @(negedge clk);
        count_run(1'b0, n);
        chk("R2 reset timeout length", n, E_RST);
        count_run(1'b1, n);
        chk("R5 after-reset watch period", n, E_WDF);
        chk("R6 wdo_n low with reset", int'(wdo_n), 0);
        chk("R3 rst high with reset", int'(rst), 1);
        count_run(1'b0, n);
        chk("R8 repeated pulse length", n, E_RST);
        chk("R7 wdo_n stays low after pulse", int'(wdo_n), 0);
        count_run(1'b1, n);
        chk("R8 pulse spacing", n, E_WDF);
    endtask

    task automatic t_kick();
        int n;
        int lows;
        while (!rst_n) @(negedge clk);
        wdi = ~wdi;
        @(negedge clk);
        @(negedge clk);
        chk("R4 kick not yet seen after two edges", int'(wdo_n), 0);
        @(negedge clk);
        chk("R7 wdo_n released by wdi change", int'(wdo_n), 1);
        count_run(1'b1, n);
        chk("R5 normal watch period after kick", n, E_WD);
        while (!rst_n) @(negedge clk);
        lows = 0;
        for (int k = 0; k < 12; k++) begin
            wdi = ~wdi;
            repeat (E_WD - 1) begin
                @(negedge clk);
                if (!rst_n) lows++;
            end
        end
        chk("R4 regular kicks keep reset released", lows, 0);
        wdi = ~wdi;
        @(negedge clk);
        wdi = ~wdi;
        @(negedge clk);
        count_run(1'b1, n);
        chk("R4 one-clock pulse restarts count", n, E_WD + 2);
    endtask

    task automatic t_low_line();
        int n;
        chk("R6 fault latched before supply drop", int'(wdo_n), 0);
        low_line = 1'b1;
        @(negedge clk);
        chk("R1 rst_n one clock after low_line", int'(rst_n), 0);
        chk("R1 wdo_n cleared by low_line", int'(wdo_n), 1);
        repeat (E_RST + E_WDF) @(negedge clk);
        chk("R1 reset held during long low_line", int'(rst_n), 0);
        low_line = 1'b0;
        @(negedge clk);
        count_run(1'b0, n);
        chk("R2 reset timeout after brownout", n, E_RST);
    endtask

    task automatic t_disable();
        int n;
        int lows;
        wdi_float = 1'b1;
        lows = 0;
        repeat (2 * (E_WDF + E_RST)) begin
            @(negedge clk);
            if (!rst_n || !wdo_n) lows++;
        end
        chk("R9 open kick input disables watchdog", lows, 0);
        wdi_float = 1'b0;
        @(negedge clk);
        count_run(1'b1, n);
        chk("R9 normal period after re-enable", n, E_WD);
        while (!rst_n) @(negedge clk);
        while (wdo_n && rst_n) @(negedge clk);
        chk("R6 fault before battery mode", int'(wdo_n), 0);
        batt_mode = 1'b1;
        @(negedge clk);
        chk("R9 battery mode clears wdo_n", int'(wdo_n), 1);
        repeat (E_RST + 2) @(negedge clk);
        lows = 0;
        repeat (3 * E_WDF) begin
            @(negedge clk);
            if (!rst_n || !wdo_n) lows++;
        end
        chk("R9 no pulses in battery mode", lows, 0);
        batt_mode = 1'b0;
    endtask

    task automatic t_modes();
        int n;
        tmo_mode = 2'b01;
        restart_supply();
        count_run(1'b0, n);
        chk("R10 fast mode reset timeout", n, F_RST);
        count_run(1'b1, n);
        chk("R10 fast mode after-reset period", n, F_WDF);
        while (!rst_n) @(negedge clk);
        wdi = ~wdi;
        repeat (3) @(negedge clk);
        count_run(1'b1, n);
        chk("R10 fast mode normal period", n, F_WD);
        tmo_mode = 2'b10;
        restart_supply();
        count_run(1'b0, n);
        chk("R10 default mode reset timeout", n, S_RST);
        count_run(1'b1, n);
        chk("R10 default mode after-reset period", n, S_WD);
        while (!rst_n) @(negedge clk);
        wdi = ~wdi;
        repeat (3) @(negedge clk);
        count_run(1'b1, n);
        chk("R10 default mode normal period", n, S_WD);
        tmo_mode = 2'b00;
    endtask

    task automatic t_tick_gating();
        int n;
        tick_every = 0;
        restart_supply();
        repeat (5 * E_RST) @(negedge clk);
        chk("R11 no ticks keeps reset asserted", int'(rst_n), 0);
        tick_every = 3;
        restart_supply();
        count_run(1'b0, n);
        chk("R11 reset timeout scales with tick rate",
            int'(n >= 3 * E_RST - 3 && n <= 3 * E_RST), 1);
        tick_every = 1;
    endtask

    initial begin
        t_reset_state();
        t_power_up_and_stuck();
        t_kick();
        t_low_line();
        t_disable();
        t_modes();
        t_tick_gating();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule